// File: doc/BRIEF.md
# Two-Wire Slave with 16-Bit Register Bank

This block lets a host microcontroller reach a bank of 16-bit control words over a two-wire serial bus. The block is always a slave. The clock line is only an input. The data line is open-drain: the block can only pull it low or let it go.

The 7-bit device address is 0011000. After the address, the master sends an 8-bit pointer. It then writes words as byte pairs, high byte first. To read, the master sets the pointer with a write, sends a repeated start with the read bit set, and then clocks words out, again high byte first. The pointer advances by one after every full word, so one transaction can move a run of consecutive registers.

One address works as a group register. A word written there is also stored in the even-numbered channel registers. In those copies the input-select bits and the de-emphasis bits keep their old values.

Top module: `i2c16_slave`

## Requirements
- R1: After reset every register reads as 0000h and the block does not drive the data line (`sda_oe_o` = 0).
- R2: The block acknowledges an address byte whose upper seven bits are 0011000. Any other address gets no acknowledge, and the rest of that transfer changes no register.
- R3: In a write, the byte after the address is the register pointer. Each following pair of bytes, high byte first, is stored at the pointer. The stored value is visible on `regs_o`, with register n at bits [16n+15:16n].
- R4: In a read, after a repeated start with the read bit (bit 0 = 1), each register is returned as two bytes, high byte first, each shifted out most significant bit first.
- R5: The pointer increments after each completed 16-bit register, in both directions. This lets a burst reach consecutive registers.
- R6: When the master does not acknowledge a read byte, the block releases the data line and drives nothing until the next start.
- R7: A STOP or a START returns the byte machine to address reception. A single data byte that has no partner byte is discarded, and the register keeps its old value.
- R8: A write to the group register 11h also writes channel registers 13h, 15h and 17h (channels 2, 4 and 6 of the six channels at 12h..17h). In those copies, bits [15:14] (input select) and bits [13:11] (de-emphasis) keep their previous values. Odd channel registers are not changed.
- R9: Pointer values of 20h and above read as 0000h, and writes to them change no register.
- R10: The data line output only changes while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both bus lines are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| regs_o | output | NREG*16 | Flattened contents of the register bank |

## Verification
The bench builds the block with its default parameters: 32 registers, the group register at 11h, and six channel registers starting at 12h. With these values a single burst can write and read back every register, and a write of many words passes through the group register on the way. The bench sweeps several group-write values over the channel range. It also covers a wrong device address, a lone byte cut off by a stop, pointers past the bank, and a master not-acknowledge in the middle of a word.

// File: rtl/i2c16_pkg.sv
package i2c16_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } bus_state_t;
endpackage

// File: rtl/i2c16_bus_sync.sv
module i2c16_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_n_sync,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] rst_pipe;
  logic [1:0] scl_pipe, sda_pipe;
  logic       scl_q, sda_q;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      scl_pipe <= 2'b11;
      sda_pipe <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[0], scl_i};
      sda_pipe <= {sda_pipe[0], sda_i};
      scl_q    <= scl_pipe[1];
      sda_q    <= sda_pipe[1];
    end
  end

  assign sda_s     = sda_pipe[1];
  assign scl_rise  = scl_pipe[1] & ~scl_q;
  assign scl_fall  = ~scl_pipe[1] & scl_q;
  assign start_det = scl_pipe[1] & scl_q & sda_q & ~sda_pipe[1];
  assign stop_det  = scl_pipe[1] & scl_q & ~sda_q & sda_pipe[1];
endmodule

// File: rtl/i2c16_regbank.sv
module i2c16_regbank #(
  parameter int          NREG      = 32,
  parameter logic [7:0]  GRP_ADDR  = 8'h11,
  parameter logic [7:0]  CH_BASE   = 8'h12,
  parameter int          NCH       = 6,
  parameter logic [15:0] KEEP_MASK = 16'hF800
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [15:0]        wr_data,
  input  logic [7:0]         rd_addr,
  output logic [15:0]        rd_data,
  output logic [NREG*16-1:0] regs_flat
);
  localparam int         IDX_W  = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [8:0] NREG_L = 9'(NREG);

  logic [15:0] word_w [NREG];
  logic        grp_hit;

  assign grp_hit = wr_en && (wr_addr == GRP_ADDR);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam int  CH_OFF  = i - int'(CH_BASE);
    localparam bit  EVEN_CH = (CH_OFF >= 0) && (CH_OFF < NCH) && ((CH_OFF % 2) == 1);
    logic        hit_self;
    logic        hit_copy;
    logic [15:0] r_q;
    logic [15:0] r_d;

    assign hit_self = wr_en && (wr_addr == 8'(i));
    assign hit_copy = EVEN_CH && grp_hit;

    always_comb begin
      if (hit_self) r_d = wr_data;
      else          r_d = (r_q & KEEP_MASK) | (wr_data & ~KEEP_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    r_q <= '0;
      else if (hit_self || hit_copy) r_q <= r_d;
    end

    assign word_w[i]            = r_q;
    assign regs_flat[i*16 +: 16] = r_q;
  end

  always_comb begin
    rd_data = '0;
    if ({1'b0, rd_addr} < NREG_L) rd_data = word_w[rd_addr[IDX_W-1:0]];
  end
endmodule

// File: rtl/i2c16_ctrl.sv
module i2c16_ctrl
  import i2c16_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0011000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_det,
  input  logic        stop_det,
  input  logic        sda_s,
  input  logic [15:0] rd_data,
  output logic [7:0]  ptr_o,
  output logic        wr_en,
  output logic [7:0]  wr_addr,
  output logic [15:0] wr_data,
  output logic        sda_oe,
  output bus_state_t  st_o
);
  localparam logic [3:0] BITS = 4'(BYTE_W);

  bus_state_t  st_q, st_d;
  logic [3:0]  cnt_q, cnt_d;
  logic [7:0]  sh_q, sh_d;
  logic [7:0]  ptr_q, ptr_d;
  logic [7:0]  hb_q, hb_d;
  logic [7:0]  tx_q, tx_d;
  logic [15:0] rw_q, rw_d;
  logic        dir_q, dir_d;
  logic        lo_q, lo_d;
  logic        nack_q, nack_d;
  logic        oe_q, oe_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    hb_d    = hb_q;
    tx_d    = tx_q;
    rw_d    = rw_q;
    dir_d   = dir_q;
    lo_d    = lo_q;
    nack_d  = nack_q;
    oe_d    = oe_q;
    wr_en   = 1'b0;
    wr_addr = ptr_q;
    wr_data = {hb_q, sh_q};

    if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
      lo_d = 1'b0;
    end else if (start_det) begin
      st_d  = ST_DEV;
      cnt_d = '0;
      oe_d  = 1'b0;
      lo_d  = 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_PTR, ST_WR: begin
          if (scl_rise && cnt_q < BITS) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == BITS) begin
            cnt_d = '0;
            if (st_q == ST_DEV) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                dir_d = sh_q[0];
                oe_d  = 1'b1;
                st_d  = ST_DEV_ACK;
              end else begin
                st_d = ST_IDLE;
              end
            end else if (st_q == ST_PTR) begin
              ptr_d = sh_q;
              oe_d  = 1'b1;
              st_d  = ST_PTR_ACK;
            end else begin
              oe_d = 1'b1;
              st_d = ST_WR_ACK;
              if (!lo_q) begin
                hb_d = sh_q;
                lo_d = 1'b1;
              end else begin
                wr_en = 1'b1;
                ptr_d = ptr_q + 8'd1;
                lo_d  = 1'b0;
              end
            end
          end
        end
        ST_DEV_ACK, ST_PTR_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            oe_d  = 1'b0;
            cnt_d = '0;
            if (st_q == ST_DEV_ACK && dir_q) begin
              st_d = ST_RD;
              rw_d = rd_data;
              tx_d = rd_data[15:8];
              oe_d = ~rd_data[15];
              lo_d = 1'b0;
            end else if (st_q == ST_DEV_ACK) begin
              st_d = ST_PTR;
            end else begin
              st_d = ST_WR;
            end
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == BITS) begin
              oe_d  = 1'b0;
              cnt_d = '0;
              st_d  = ST_RD_ACK;
            end else begin
              tx_d = {tx_q[6:0], 1'b0};
              oe_d = ~tx_q[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
            if (lo_q) ptr_d = ptr_q + 8'd1;
          end else if (scl_fall) begin
            if (nack_q) begin
              st_d = ST_IDLE;
              oe_d = 1'b0;
            end else begin
              st_d  = ST_RD;
              cnt_d = '0;
              if (!lo_q) begin
                tx_d = rw_q[7:0];
                oe_d = ~rw_q[7];
                lo_d = 1'b1;
              end else begin
                rw_d = rd_data;
                tx_d = rd_data[15:8];
                oe_d = ~rd_data[15];
                lo_d = 1'b0;
              end
            end
          end
        end
        default: begin
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      hb_q   <= '0;
      tx_q   <= '0;
      rw_q   <= '0;
      dir_q  <= 1'b0;
      lo_q   <= 1'b0;
      nack_q <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      ptr_q  <= ptr_d;
      hb_q   <= hb_d;
      tx_q   <= tx_d;
      rw_q   <= rw_d;
      dir_q  <= dir_d;
      lo_q   <= lo_d;
      nack_q <= nack_d;
      oe_q   <= oe_d;
    end
  end

  assign ptr_o  = ptr_q;
  assign sda_oe = oe_q;
  assign st_o   = st_q;
endmodule

// File: rtl/i2c16_slave.sv
module i2c16_slave
  import i2c16_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR  = 7'b0011000,
  parameter int          NREG      = 32,
  parameter logic [7:0]  GRP_ADDR  = 8'h11,
  parameter logic [7:0]  CH_BASE   = 8'h12,
  parameter int          NCH       = 6,
  parameter logic [15:0] KEEP_MASK = 16'hF800
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [NREG*16-1:0] regs_o
);
  logic        rst_n_sync;
  logic        sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic        wr_en;
  logic [7:0]  wr_addr, ptr;
  logic [15:0] wr_data, rd_data;
  bus_state_t  bus_st;

  i2c16_bus_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .rst_n_sync (rst_n_sync),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det)
  );

  i2c16_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .rd_data   (rd_data),
    .ptr_o     (ptr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe_o),
    .st_o      (bus_st)
  );

  i2c16_regbank #(
    .NREG      (NREG),
    .GRP_ADDR  (GRP_ADDR),
    .CH_BASE   (CH_BASE),
    .NCH       (NCH),
    .KEEP_MASK (KEEP_MASK)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (ptr),
    .rd_data   (rd_data),
    .regs_flat (regs_o)
  );
endmodule

// File: rtl/i2c16_slave_chk.sv
module i2c16_slave_chk
  import i2c16_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       start_det,
  input logic       stop_det,
  input bus_state_t st
);
  // R10: output edges only while the clock line is low
  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R6: nothing driven once the machine has gone idle
  assert_idle_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  // R2: a matching address is acknowledged for the whole ack slot
  assert_dev_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEV_ACK) |-> sda_oe);

  // R3: pointer byte and data bytes are acknowledged
  assert_wr_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PTR_ACK || st == ST_WR_ACK) |-> sda_oe);

  // R7: start restarts address reception, stop goes idle
  assert_start_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (st == ST_DEV && !sda_oe));

  assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE));
endmodule

bind i2c16_slave i2c16_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe_o),
  .start_det (start_det),
  .stop_det  (stop_det),
  .st        (bus_st)
);

// File: tb/i2c16_slave_tb.sv
`timescale 1ns/1ps
module i2c16_slave_tb;
  localparam int NREG = 32;
  localparam int Q    = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [NREG*16-1:0] regs;

  int vec_cnt = 0;
  int err_cnt = 0;
  logic [15:0] mdl [NREG];
  logic [15:0] wdat [64];

  always #5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  i2c16_slave u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe),
    .regs_o   (regs)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mdl_rd(input logic [7:0] a);
    return (a < NREG) ? mdl[a] : 16'h0000;
  endfunction

  task automatic mdl_wr(input logic [7:0] a, input logic [15:0] d);
    if (a < NREG) mdl[a] = d;
    if (a == 8'h11)
      for (int e = 8'h13; e <= 8'h17; e += 2)
        mdl[e] = (mdl[e] & 16'hF800) | (d & 16'h07FF);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; #Q; scl = 1'b1; #Q; m_sda = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; #Q; scl = 1'b1; #Q; m_sda = 1'b1; #Q;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
    end
    m_sda = 1'b1; #Q; scl = 1'b1; #Q; acked = (sda_bus == 1'b0); #Q; scl = 1'b0; #Q;
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; #Q; scl = 1'b1; #Q; b[i] = sda_bus; #Q; scl = 1'b0; #Q;
    end
    m_sda = ~mack; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q; m_sda = 1'b1;
  endtask

  // write n words from wdat starting at pointer p
  task automatic wr_regs(input logic [7:0] p, input int n);
    logic ack;
    bus_start();
    put_byte(8'h30, ack);
    check("R2 address ack", 16'(ack), 16'h1);
    put_byte(p, ack);
    check("R3 pointer ack", 16'(ack), 16'h1);
    for (int k = 0; k < n; k++) begin
      put_byte(wdat[k][15:8], ack);
      put_byte(wdat[k][7:0], ack);
      mdl_wr(p + 8'(k), wdat[k]);
    end
    bus_stop();
  endtask

  task automatic rd_regs(input logic [7:0] p, input int n, input string req);
    logic ack;
    logic [7:0] hi, lo;
    bus_start();
    put_byte(8'h30, ack);
    put_byte(p, ack);
    bus_start();
    put_byte(8'h31, ack);
    check("R4 read address ack", 16'(ack), 16'h1);
    for (int k = 0; k < n; k++) begin
      get_byte(1'b1, hi);
      get_byte(k != n - 1, lo);
      check(req, {hi, lo}, mdl_rd(p + 8'(k)));
    end
    bus_stop();
  endtask

  initial begin : watchdog
    #(30_000_000);
    err_cnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin : stim
    logic ack;
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) mdl[i] = 16'h0000;
    #100; rst_n = 1'b1; #300;

    // R1: reset state
    check("R1 data line released", 16'(sda_oe), 16'h0);
    rd_regs(8'h00, NREG, "R1 reset value");

    // R3/R5: full burst write then burst read
    for (int k = 0; k < NREG; k++) wdat[k] = 16'(k * 16'h1357) ^ 16'hA5C3;
    wr_regs(8'h00, NREG);
    for (int k = 0; k < NREG; k++) check("R3 regs_o", regs[k*16 +: 16], mdl[k]);
    rd_regs(8'h00, NREG, "R5 burst read");
    rd_regs(8'h1D, 3, "R4 short read");

    // R8: group write sweep, check channel range
    for (int v = 0; v < 4; v++) begin
      wdat[0] = (v == 0) ? 16'hFFFF : (v == 1) ? 16'h0000 : (v == 2) ? 16'h5A5A : 16'h87F1;
      wr_regs(8'h11, 1);
      rd_regs(8'h11, 7, "R8 group copy");
    end

    // R2: wrong device address, transfer ignored
    bus_start();
    put_byte(8'h32, ack);
    check("R2 foreign address no ack", 16'(ack), 16'h0);
    put_byte(8'h02, ack);
    put_byte(8'hDE, ack);
    put_byte(8'hAD, ack);
    bus_stop();
    check("R2 reg unchanged", regs[2*16 +: 16], mdl[2]);

    // R7: lone byte cut by stop is discarded
    bus_start();
    put_byte(8'h30, ack);
    put_byte(8'h04, ack);
    put_byte(8'h99, ack);
    bus_stop();
    check("R7 half pair dropped", regs[4*16 +: 16], mdl[4]);
    rd_regs(8'h04, 1, "R7 readback");

    // R9: out of range pointer
    wdat[0] = 16'hBEEF; wdat[1] = 16'hCAFE;
    wr_regs(8'h1F, 2);
    rd_regs(8'h1E, 3, "R9 range end");
    wr_regs(8'h40, 1);
    rd_regs(8'h40, 1, "R9 out of range");
    for (int k = 0; k < NREG; k++) check("R9 bank intact", regs[k*16 +: 16], mdl[k]);

    // R6: master nack after the high byte
    bus_start();
    put_byte(8'h30, ack);
    put_byte(8'h05, ack);
    bus_start();
    put_byte(8'h31, ack);
    get_byte(1'b0, b);
    check("R6 high byte", {8'h00, b}, {8'h00, mdl[5][15:8]});
    #(2*Q);
    check("R6 line released", 16'(sda_oe), 16'h0);
    bus_stop();
    rd_regs(8'h05, 2, "R6 resumed read");

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule